// File: doc/BRIEF.md
# Interruption State Capture Unit

This block records the machine state at the moment an interruption is delivered. On each cycle in which the deliver strobe is high, it works out which status word is current, including one still in flight. It decides whether the collection-enable bit allows the saved copies to be overwritten. It then writes the saved status, the saved instruction address and the saved slot index. It also forms the trap-code vector, picks the single trap that is taken, and produces the status word the handler starts with.

The saved slot and saved address follow fixed rules. A fault or external interrupt points at the interrupted instruction. A trap points at the instruction that would have run next, which moves to the next 16-byte bundle when the trapping instruction ends the bundle. In the alternate instruction-set mode the slot is always 0, and a trap uses an address supplied by the decoder for the following instruction.

Top module: `irq_state_capture`

## Requirements
- R1: A synchronous reset clears every output register (saved status, saved address, saved slot, trap code, selected trap, new status) to zero.
- R2: In a cycle without the deliver strobe, every output keeps its value.
- R3: On delivery with the collection-enable bit (status bit 13) of the effective status at 0, saved status, saved address and saved slot keep their values. Trap code, selected trap and new status still update.
- R4: The effective status is `inflight_status` when `inflight_valid` is 1 and `cur_status` otherwise. On delivery with collection enabled, saved status takes the effective status.
- R5: For a fault (class 0) or an external interrupt (class 2, and class 3 handled the same way), outside alternate mode, the saved slot is `cur_slot`, or 1 when `wide_instr` is set. The saved address is `cur_ip`.
- R6: For a trap (class 1) outside alternate mode, the saved slot is the next slot: 0→1 and 1→2. From slot 2, or from a wide instruction, the saved slot is 0 and the saved address is `cur_ip + 16`. Otherwise the saved address is `cur_ip`.
- R7: In alternate mode the saved slot is 0. The saved address is `alt_next_ip` for a trap and `cur_ip` for any other class.
- R8: The trap code equals `trap_req` for a trap and is zero for any other class. Bit 0 is unimplemented-address, bit 1 is lower-privilege transfer and bit 2 is single-step.
- R9: The selected trap is one-hot on the lowest-numbered set bit of the trap code (bit 0 highest priority), or zero when the code is zero.
- R10: The new status is the effective status with bit 13 (collection enable) and bit 14 (interrupt enable) cleared and bit 1 (endian) set to `sys_endian`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| deliver | input | 1 | Interruption delivery strobe |
| irq_class | input | 2 | 0 fault, 1 trap, 2 external, 3 handled as external |
| cur_status | input | STAT_W | Architected status word |
| inflight_valid | input | 1 | A newer status value is in flight |
| inflight_status | input | STAT_W | The in-flight status value |
| sys_endian | input | 1 | System default endian setting |
| cur_ip | input | IP_W | Address of the interrupted bundle or instruction |
| alt_next_ip | input | IP_W | Alternate-mode address of the following instruction |
| cur_slot | input | 2 | Slot of the instruction within its bundle |
| wide_instr | input | 1 | Instruction occupies two slots (slots 1 and 2) |
| alt_mode | input | 1 | Alternate instruction-set mode |
| trap_req | input | 3 | Trap requests, bit 0 highest priority |
| saved_status | output | STAT_W | Saved status word |
| saved_ip | output | IP_W | Saved instruction address |
| saved_slot | output | 2 | Saved slot index |
| trap_code | output | 3 | One bit per trap that fired |
| trap_sel | output | 3 | One-hot trap taken |
| new_status | output | STAT_W | Status word for the handler |

## Verification
Every output is a register loaded on the edge where `deliver` is high, so each result is due exactly one clock edge after the stimulus. The bench changes inputs on the falling edge and updates its expected values in the same step. It then compares at the next falling edge, half a period after the capturing edge. Idle cycles are checked the same way, and each one confirms that nothing moved.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

  typedef enum logic [1:0] {
    CLS_FAULT = 2'd0,
    CLS_TRAP  = 2'd1,
    CLS_EXT   = 2'd2,
    CLS_RSVD  = 2'd3
  } irq_class_e;

  localparam int SLOT_W       = 2;
  localparam int NTRAP        = 3;
  localparam int BUNDLE_BYTES = 16;
  localparam logic [SLOT_W-1:0] LAST_SLOT = 2'd2;

  // True when the instruction after this one lies in the next bundle.
  function automatic logic ends_bundle(logic [SLOT_W-1:0] slot, logic wide);
    return wide || (slot >= LAST_SLOT);
  endfunction

  // Slot of the instruction that follows.
  function automatic logic [SLOT_W-1:0] follow_slot(logic [SLOT_W-1:0] slot, logic wide);
    return ends_bundle(slot, wide) ? '0 : slot + 1'b1;
  endfunction

  // Slot reported for a fault or external interrupt.
  function automatic logic [SLOT_W-1:0] here_slot(logic [SLOT_W-1:0] slot, logic wide);
    return wide ? 2'd1 : slot;
  endfunction

endpackage

// File: rtl/irqcap_status_upd.sv
module irqcap_status_upd #(
  parameter int W       = 32,
  parameter int IC_BIT  = 13,
  parameter int IE_BIT  = 14,
  parameter int END_BIT = 1
) (
  input  logic [W-1:0] cur_status,
  input  logic         inflight_valid,
  input  logic [W-1:0] inflight_status,
  input  logic         sys_endian,
  output logic [W-1:0] eff_status,
  output logic [W-1:0] handler_status,
  output logic         collect_en
);

  always_comb begin
    eff_status = inflight_valid ? inflight_status : cur_status;
    collect_en = eff_status[IC_BIT];
    handler_status          = eff_status;
    handler_status[IC_BIT]  = 1'b0;
    handler_status[IE_BIT]  = 1'b0;
    handler_status[END_BIT] = sys_endian;
  end

endmodule

// File: rtl/irqcap_slot_ip.sv
module irqcap_slot_ip
  import irqcap_pkg::*;
#(
  parameter int IP_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IP_W-1:0]   cur_ip,
  input  logic [IP_W-1:0]   alt_next_ip,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              wide_instr,
  input  logic              alt_mode,
  input  logic              is_trap,
  output logic [SLOT_W-1:0] slot_o,
  output logic [IP_W-1:0]   ip_o,
  output logic              bundle_wrap
);

  localparam logic [IP_W-1:0] STEP = IP_W'(BUNDLE_BYTES);

  always_comb begin
    bundle_wrap = is_trap && !alt_mode && ends_bundle(cur_slot, wide_instr);
    if (alt_mode) begin
      slot_o = '0;
      ip_o   = is_trap ? alt_next_ip : cur_ip;
    end else if (is_trap) begin
      slot_o = follow_slot(cur_slot, wide_instr);
      ip_o   = bundle_wrap ? cur_ip + STEP : cur_ip;
    end else begin
      slot_o = here_slot(cur_slot, wide_instr);
      ip_o   = cur_ip;
    end
  end

  a_r6_wrap_slot_zero: assert property (@(posedge clk) disable iff (rst)
    bundle_wrap |-> (slot_o == '0) && (ip_o != cur_ip));

  a_r7_alt_slot_zero: assert property (@(posedge clk) disable iff (rst)
    alt_mode |-> slot_o == '0);

  a_r5_wide_here: assert property (@(posedge clk) disable iff (rst)
    (!is_trap && !alt_mode && wide_instr) |-> (slot_o == 2'd1) && (ip_o == cur_ip));

endmodule

// File: rtl/irqcap_trap_prio.sv
module irqcap_trap_prio #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] sel
);

  logic [N:0] higher;
  assign higher[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign sel[i]      = req[i] & ~higher[i];
    assign higher[i+1] = higher[i] | req[i];
  end

  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  a_r9_subset: assert property (@(posedge clk) disable iff (rst)
    (sel & ~req) == '0);

  a_r9_any_taken: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (sel != '0));

endmodule

// File: rtl/irq_state_capture.sv
module irq_state_capture
  import irqcap_pkg::*;
#(
  parameter int STAT_W  = 32,
  parameter int IP_W    = 64,
  parameter int IC_BIT  = 13,
  parameter int IE_BIT  = 14,
  parameter int END_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              deliver,
  input  logic [1:0]        irq_class,
  input  logic [STAT_W-1:0] cur_status,
  input  logic              inflight_valid,
  input  logic [STAT_W-1:0] inflight_status,
  input  logic              sys_endian,
  input  logic [IP_W-1:0]   cur_ip,
  input  logic [IP_W-1:0]   alt_next_ip,
  input  logic [1:0]        cur_slot,
  input  logic              wide_instr,
  input  logic              alt_mode,
  input  logic [2:0]        trap_req,
  output logic [STAT_W-1:0] saved_status,
  output logic [IP_W-1:0]   saved_ip,
  output logic [1:0]        saved_slot,
  output logic [2:0]        trap_code,
  output logic [2:0]        trap_sel,
  output logic [STAT_W-1:0] new_status
);

  irq_class_e        cls;
  logic              is_trap;
  logic [STAT_W-1:0] eff_status;
  logic [STAT_W-1:0] handler_status;
  logic              collect_en;
  logic              capture_ok;
  logic [SLOT_W-1:0] slot_next;
  logic [IP_W-1:0]   ip_next;
  logic              bundle_wrap;
  logic [NTRAP-1:0]  code_next;
  logic [NTRAP-1:0]  sel_next;

  assign cls        = irq_class_e'(irq_class);
  assign is_trap    = (cls == CLS_TRAP);
  assign code_next  = is_trap ? trap_req : '0;
  assign capture_ok = deliver && collect_en;

  irqcap_status_upd #(
    .W(STAT_W), .IC_BIT(IC_BIT), .IE_BIT(IE_BIT), .END_BIT(END_BIT)
  ) u_status (
    .cur_status     (cur_status),
    .inflight_valid (inflight_valid),
    .inflight_status(inflight_status),
    .sys_endian     (sys_endian),
    .eff_status     (eff_status),
    .handler_status (handler_status),
    .collect_en     (collect_en)
  );

  irqcap_slot_ip #(.IP_W(IP_W)) u_slot_ip (
    .clk        (clk),
    .rst        (rst),
    .cur_ip     (cur_ip),
    .alt_next_ip(alt_next_ip),
    .cur_slot   (cur_slot),
    .wide_instr (wide_instr),
    .alt_mode   (alt_mode),
    .is_trap    (is_trap),
    .slot_o     (slot_next),
    .ip_o       (ip_next),
    .bundle_wrap(bundle_wrap)
  );

  irqcap_trap_prio #(.N(NTRAP)) u_prio (
    .clk(clk),
    .rst(rst),
    .req(code_next),
    .sel(sel_next)
  );

  // Auxiliary state: written only when collection is enabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      saved_status <= '0;
      saved_ip     <= '0;
      saved_slot   <= '0;
    end else if (capture_ok) begin
      saved_status <= eff_status;
      saved_ip     <= ip_next;
      saved_slot   <= slot_next;
    end
  end

  // Always written on delivery.
  always_ff @(posedge clk) begin
    if (rst) begin
      trap_code  <= '0;
      trap_sel   <= '0;
      new_status <= '0;
    end else if (deliver) begin
      trap_code  <= code_next;
      trap_sel   <= sel_next;
      new_status <= handler_status;
    end
  end

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !deliver |=> $stable(saved_status) && $stable(saved_ip) && $stable(saved_slot)
                 && $stable(trap_code) && $stable(trap_sel) && $stable(new_status));

  a_r3_no_collect: assert property (@(posedge clk) disable iff (rst)
    (deliver && !collect_en) |=> $stable(saved_status) && $stable(saved_ip)
                                 && $stable(saved_slot));

  a_r4_copy: assert property (@(posedge clk) disable iff (rst)
    (deliver && collect_en) |=> saved_status == $past(eff_status));

  a_r10_enables_off: assert property (@(posedge clk) disable iff (rst)
    deliver |=> !new_status[IC_BIT] && !new_status[IE_BIT]
                && (new_status[END_BIT] == $past(sys_endian)));

  a_r8_code_class: assert property (@(posedge clk) disable iff (rst)
    (deliver && !is_trap) |=> (trap_code == '0) && (trap_sel == '0));

  a_r9_sel_in_code: assert property (@(posedge clk) disable iff (rst)
    (trap_sel & ~trap_code) == '0);

endmodule

// File: tb/sim_irq_state_capture.sv
`timescale 1ns/1ps
module sim_irq_state_capture;

  localparam int CLK_P = 10;
  localparam int SW    = 32;
  localparam int IW    = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          deliver = 1'b0;
  logic [1:0]    irq_class = '0;
  logic [SW-1:0] cur_status = '0;
  logic          inflight_valid = 1'b0;
  logic [SW-1:0] inflight_status = '0;
  logic          sys_endian = 1'b0;
  logic [IW-1:0] cur_ip = '0;
  logic [IW-1:0] alt_next_ip = '0;
  logic [1:0]    cur_slot = '0;
  logic          wide_instr = 1'b0;
  logic          alt_mode = 1'b0;
  logic [2:0]    trap_req = '0;
  logic [SW-1:0] saved_status;
  logic [IW-1:0] saved_ip;
  logic [1:0]    saved_slot;
  logic [2:0]    trap_code;
  logic [2:0]    trap_sel;
  logic [SW-1:0] new_status;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [SW-1:0] e_ss = '0;
  logic [IW-1:0] e_sip = '0;
  logic [1:0]    e_slot = '0;
  logic [2:0]    e_code = '0;
  logic [2:0]    e_sel = '0;
  logic [SW-1:0] e_ns = '0;
  string         ip_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  irq_state_capture u0 (
    .clk(clk), .rst(rst), .deliver(deliver), .irq_class(irq_class),
    .cur_status(cur_status), .inflight_valid(inflight_valid),
    .inflight_status(inflight_status), .sys_endian(sys_endian),
    .cur_ip(cur_ip), .alt_next_ip(alt_next_ip), .cur_slot(cur_slot),
    .wide_instr(wide_instr), .alt_mode(alt_mode), .trap_req(trap_req),
    .saved_status(saved_status), .saved_ip(saved_ip), .saved_slot(saved_slot),
    .trap_code(trap_code), .trap_sel(trap_sel), .new_status(new_status)
  );

  function automatic logic [1:0] m_slot(logic [1:0] c, logic [1:0] s, logic w, logic a);
    if (a) return 2'd0;
    if (c != 2'd1) return w ? 2'd1 : s;
    if (w) return 2'd0;
    case (s)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [IW-1:0] m_ip(logic [1:0] c, logic [1:0] s, logic w, logic a,
                                         logic [IW-1:0] ip, logic [IW-1:0] anip);
    if (a) return (c == 2'd1) ? anip : ip;
    if (c == 2'd1 && (w || s == 2'd2)) return ip + 64'd16;
    return ip;
  endfunction

  function automatic logic [2:0] m_sel(logic [2:0] code);
    if (code[0]) return 3'b001;
    if (code[1]) return 3'b010;
    if (code[2]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(string stag, string ctag);
    check(ctag, 64'(saved_status), 64'(e_ss));
    check(ip_tag, saved_ip, e_sip);
    check(ip_tag, 64'(saved_slot), 64'(e_slot));
    check("R8", 64'(trap_code), 64'(e_code));
    check("R9", 64'(trap_sel), 64'(e_sel));
    check(stag, 64'(new_status), 64'(e_ns));
  endtask

  // Called at a falling edge; checks at the next falling edge.
  task automatic cyc(input logic dlv);
    logic [SW-1:0] eff;
    string ctag;
    deliver = dlv;
    ctag = "R2";
    if (!dlv) ip_tag = "R2";
    if (dlv) begin
      eff = inflight_valid ? inflight_status : cur_status;
      if (eff[13]) begin
        ctag   = "R4";
        e_ss   = eff;
        e_sip  = m_ip(irq_class, cur_slot, wide_instr, alt_mode, cur_ip, alt_next_ip);
        e_slot = m_slot(irq_class, cur_slot, wide_instr, alt_mode);
        if (alt_mode) ip_tag = "R7";
        else if (irq_class == 2'd1) ip_tag = "R6";
        else ip_tag = "R5";
      end else begin
        ctag = "R3";
        ip_tag = "R3";
      end
      e_code = (irq_class == 2'd1) ? trap_req : 3'b000;
      e_sel  = m_sel(e_code);
      e_ns   = eff;
      e_ns[13] = 1'b0;
      e_ns[14] = 1'b0;
      e_ns[1]  = sys_endian;
    end
    @(negedge clk);
    deliver = 1'b0;
    check_all(dlv ? "R10" : "R2", ctag);
  endtask

  task automatic set_in(logic [1:0] c, logic [1:0] s, logic w, logic a, logic [2:0] rq,
                        logic [SW-1:0] st, logic [IW-1:0] ip);
    irq_class = c; cur_slot = s; wide_instr = w; alt_mode = a; trap_req = rq;
    cur_status = st; cur_ip = ip; inflight_valid = 1'b0;
    alt_next_ip = ip + 64'd5; sys_endian = ~sys_endian;
  endtask

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ip_tag = "R1";
    check_all("R1", "R1");  // reset state all zero

    // R6: trap on slot 2 wraps to next bundle
    set_in(2'd1, 2'd2, 1'b0, 1'b0, 3'b100, 32'h0000_2000, 64'h1000);
    cyc(1'b1);
    // R6: trap on wide instruction
    set_in(2'd1, 2'd1, 1'b1, 1'b0, 3'b110, 32'hFFFF_FFFF, 64'h2000);
    cyc(1'b1);
    // R6: trap on slot 0, same bundle
    set_in(2'd1, 2'd0, 1'b0, 1'b0, 3'b111, 32'h0000_6002, 64'h3000);
    cyc(1'b1);
    // R5: wide fault reports slot 1
    set_in(2'd0, 2'd2, 1'b1, 1'b0, 3'b111, 32'h0000_2000, 64'h4000);
    cyc(1'b1);
    // R5: external interrupt on slot 2
    set_in(2'd2, 2'd2, 1'b0, 1'b0, 3'b001, 32'h0000_2001, 64'h5000);
    cyc(1'b1);
    // R7: alternate-mode trap
    set_in(2'd1, 2'd2, 1'b0, 1'b1, 3'b010, 32'h0000_2000, 64'h6000);
    cyc(1'b1);
    // R3: collection disabled, saved state held
    set_in(2'd1, 2'd2, 1'b0, 1'b0, 3'b011, 32'h0000_4fff, 64'h7000);
    cyc(1'b1);
    // R4: in-flight status overrides
    set_in(2'd0, 2'd1, 1'b0, 1'b0, 3'b000, 32'h0000_0000, 64'h8000);
    inflight_valid = 1'b1; inflight_status = 32'hA5A5_2000;
    cyc(1'b1);
    // R2: idle cycle, inputs wiggle
    set_in(2'd1, 2'd0, 1'b1, 1'b1, 3'b111, 32'h1234_6000, 64'h9000);
    cyc(1'b0);

    for (int i = 0; i < 600; i++) begin
      set_in(2'($urandom % 4), 2'($urandom % 3), 1'($urandom % 4 == 0),
             1'($urandom % 5 == 0), 3'($urandom), $urandom,
             {$urandom, $urandom});
      inflight_valid  = 1'($urandom % 3 == 0);
      inflight_status = $urandom;
      alt_next_ip     = {$urandom, $urandom};
      sys_endian      = 1'($urandom);
      cyc(1'($urandom % 4 != 0));
    end

    // R1: reset in the middle clears all outputs again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    e_ss = '0; e_sip = '0; e_slot = '0; e_code = '0; e_sel = '0; e_ns = '0;
    ip_tag = "R1";
    check_all("R1", "R1");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule